// File: doc/BRIEF.md
# Little-Endian Load/Store Lane Aligner

This block sits between a processor's 32-bit register file and a 32-bit little-endian memory data bus. It shapes data for byte and word accesses in both directions. For stores, it forms the word driven onto the bus and the per-lane write strobes. For loads, it forms the value returned to the destination register from the word read off the bus. The inputs it uses are the access kind and the two low address bits.

The store path is combinational from its inputs. The load path captures its formatted result in a register, together with a valid flag, on the clock edge at which the read word is presented with `rd_valid` high. A word load from an address that is not word aligned does not fault. The bus word is rotated so that the addressed byte lands in the low lane. This leaves a halfword at offset 0 or 2 in bits 15:0, ready for software to clear or sign-extend.

Top module: `ls_lane_aligner`

## Requirements
- R1: A byte load (`acc_kind` = 2'b00) selects its byte from the bus lane named by `addr_lo`: 0 gives bits 7:0, 1 gives bits 15:8, 2 gives bits 23:16 and 3 gives bits 31:24.
- R2: A byte load returns the selected byte in `ld_data[7:0]`, and bits 31:8 of `ld_data` are zero.
- R3: A word load (`acc_kind` = 2'b01) returns the bus word rotated right by 8 times `addr_lo`. The bytes below the addressed one wrap into the upper bits, and offset 0 returns the bus word unchanged.
- R4: A word load at offset 2 returns bus bits 31:16 in `ld_data[15:0]` and bus bits 15:0 in `ld_data[31:16]`.
- R5: A byte store (`acc_kind` = 2'b10) drives `st_data[7:0]` onto all four byte lanes of `bus_wdata`.
- R6: A word store (`acc_kind` = 2'b11) drives `st_data` onto `bus_wdata` unchanged for every value of `addr_lo`.
- R7: A byte store asserts exactly one bit of `bus_wstrb`, the bit numbered by `addr_lo`. A word store asserts all four bits. A load asserts none.
- R8: When `rd_valid` is high with a load kind at a rising clock edge, `ld_valid` is high and `ld_data` holds the formatted result after that edge. At any other edge `ld_valid` goes low and `ld_data` keeps its previous value.
- R9: A synchronous active-high `rst` clears `ld_valid` and `ld_data` to zero at the next rising edge, and this takes priority over a capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_kind | input | 2 | Bit 1: 1 = store, 0 = load; bit 0: 1 = word, 0 = byte |
| addr_lo | input | 2 | Low two address bits (byte offset within the word) |
| st_data | input | 32 | Register value to store |
| rd_valid | input | 1 | Read word on `rd_data` is accepted this cycle |
| rd_data | input | 32 | Word read from the memory bus |
| bus_wdata | output | 32 | Word driven onto the memory bus for stores |
| bus_wstrb | output | 4 | Per-lane write strobes, bit i for bits 8i+7:8i |
| ld_valid | output | 1 | Load result valid (one cycle after capture) |
| ld_data | output | 32 | Formatted value for the destination register |

## Verification
The bench builds the block with its default parameters: a 32-bit data path split into four 8-bit lanes. That gives a 2-bit offset, so all sixteen pairs of access kind and offset can be covered, each several times with random data and with a fixed table of hand-computed vectors. With four lanes, both wrap-around cases of the rotate can be reached (offsets 1 and 3), as well as the halfword case at offset 2. Directed steps then exercise holding the load register, a store kind presented with `rd_valid`, and reset taking priority over a capture.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

  // Access kind: bit 1 selects store, bit 0 selects word size.
  typedef enum logic [1:0] {
    K_LD_BYTE = 2'b00,
    K_LD_WORD = 2'b01,
    K_ST_BYTE = 2'b10,
    K_ST_WORD = 2'b11
  } acc_kind_t;

  function automatic logic kind_is_store(input acc_kind_t k);
    return k[1];
  endfunction

  function automatic logic kind_is_word(input acc_kind_t k);
    return k[0];
  endfunction

endpackage

// File: rtl/lsa_load_fmt.sv
module lsa_load_fmt #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              is_word,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] fmt_word
);

  logic [LANE_W-1:0] in_lane  [LANES];
  logic [LANE_W-1:0] rot_lane [LANES];
  logic [DATA_W-1:0] rotated;

  // Split the bus word into lanes.
  for (genvar g = 0; g < LANES; g++) begin : g_split
    assign in_lane[g] = rd_word[g*LANE_W +: LANE_W];
  end

  // Right rotate by whole lanes: output lane i takes input lane (i + off) mod LANES.
  // The offset width wraps the sum, which gives the modulo for power-of-two lane counts.
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      rot_lane[i] = in_lane[OFF_W'(i) + off];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_join
    assign rotated[g*LANE_W +: LANE_W] = rot_lane[g];
  end

  // A byte load reuses the rotate network: the addressed byte is already in lane 0.
  always_comb begin
    if (is_word) begin
      fmt_word = rotated;
    end else begin
      fmt_word = '0;
      fmt_word[LANE_W-1:0] = rotated[LANE_W-1:0];
    end
  end

endmodule

// File: rtl/lsa_store_fmt.sv
module lsa_store_fmt #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              is_store,
  input  logic              is_word,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] st_word,
  output logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  wstrb
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // Word store passes the register through; byte store replicates the low lane.
    assign wdata[g*LANE_W +: LANE_W] = is_word ? st_word[g*LANE_W +: LANE_W]
                                               : st_word[LANE_W-1:0];
    assign wstrb[g] = is_store && (is_word || (off == OFF_W'(g)));
  end

  AST_BYTE_ONE_STRB: assert property (@(posedge clk) disable iff (rst)
    (is_store && !is_word) |-> ($countones(wstrb) == 1)); // R7
  AST_BYTE_STRB_LANE: assert property (@(posedge clk) disable iff (rst)
    (is_store && !is_word) |-> wstrb[off]); // R7
  AST_WORD_ALL_STRB: assert property (@(posedge clk) disable iff (rst)
    (is_store && is_word) |-> (&wstrb)); // R7
  AST_LOAD_NO_STRB: assert property (@(posedge clk) disable iff (rst)
    !is_store |-> (wstrb == '0)); // R7
  AST_WORD_PASS: assert property (@(posedge clk) disable iff (rst)
    (is_store && is_word) |-> (wdata == st_word)); // R6

endmodule

// File: rtl/lsa_load_reg.sv
module lsa_load_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic [DATA_W-1:0] cap_word,
  output logic              q_valid,
  output logic [DATA_W-1:0] q_word
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_word  <= '0;
    end else begin
      q_valid <= cap;
      if (cap) begin
        q_word <= cap_word;
      end
    end
  end

  AST_CAP_VALID: assert property (@(posedge clk) disable iff (rst)
    cap |=> q_valid); // R8
  AST_NO_CAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cap |=> (!q_valid && $stable(q_word))); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!q_valid && q_word == '0)); // R9

endmodule

// File: rtl/ls_lane_aligner.sv
module ls_lane_aligner #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        acc_kind,
  input  logic [OFF_W-1:0]  addr_lo,
  input  logic [DATA_W-1:0] st_data,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [LANES-1:0]  bus_wstrb,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data
);

  import lsa_pkg::*;

  acc_kind_t         kind;
  logic              is_store;
  logic              is_word;
  logic              load_cap;
  logic [DATA_W-1:0] load_fmt;

  assign kind     = acc_kind_t'(acc_kind);
  assign is_store = kind_is_store(kind);
  assign is_word  = kind_is_word(kind);
  assign load_cap = rd_valid && !is_store;

  lsa_load_fmt #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_load_fmt (
    .is_word  (is_word),
    .off      (addr_lo),
    .rd_word  (rd_data),
    .fmt_word (load_fmt)
  );

  lsa_store_fmt #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_store_fmt (
    .clk      (clk),
    .rst      (rst),
    .is_store (is_store),
    .is_word  (is_word),
    .off      (addr_lo),
    .st_word  (st_data),
    .wdata    (bus_wdata),
    .wstrb    (bus_wstrb)
  );

  lsa_load_reg #(.DATA_W(DATA_W)) u_load_reg (
    .clk      (clk),
    .rst      (rst),
    .cap      (load_cap),
    .cap_word (load_fmt),
    .q_valid  (ld_valid),
    .q_word   (ld_data)
  );

  AST_BYTE_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && kind == K_LD_BYTE) |=> (ld_data[DATA_W-1:LANE_W] == '0)); // R2
  AST_WORD_OFF0_PASS: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && kind == K_LD_WORD && addr_lo == '0) |=> (ld_data == $past(rd_data))); // R3
  AST_BYTE_LANE_SEL: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && kind == K_LD_BYTE) |=>
      (ld_data[LANE_W-1:0] == $past(rd_data[addr_lo*LANE_W +: LANE_W]))); // R1
  AST_BYTE_REPLICATE: assert property (@(posedge clk) disable iff (rst)
    (kind == K_ST_BYTE) |-> (bus_wdata[DATA_W-1 -: LANE_W] == st_data[LANE_W-1:0])); // R5

endmodule

// File: tb/ls_lane_aligner_tb.sv
module ls_lane_aligner_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  acc_kind;
  logic [1:0]  addr_lo;
  logic [31:0] st_data;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [31:0] bus_wdata;
  logic [3:0]  bus_wstrb;
  logic        ld_valid;
  logic [31:0] ld_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ls_lane_aligner dut_i (
    .clk(clk), .rst(rst), .acc_kind(acc_kind), .addr_lo(addr_lo),
    .st_data(st_data), .rd_valid(rd_valid), .rd_data(rd_data),
    .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb),
    .ld_valid(ld_valid), .ld_data(ld_data)
  );

  // Vector table: kind, offset, store data, read data, expected wdata, strobes, load result.
  localparam int NV = 12;
  localparam logic [1:0]  V_KIND [NV] = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd1,
                                         2'd1, 2'd1, 2'd2, 2'd2, 2'd3, 2'd3};
  localparam logic [1:0]  V_OFF  [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1,
                                         2'd2, 2'd3, 2'd2, 2'd0, 2'd3, 2'd1};
  localparam logic [31:0] V_ST   = 32'h1234_5678;
  localparam logic [31:0] V_RD   = 32'hA1B2_C3D4;
  localparam logic [31:0] V_WD   [NV] = '{32'h1234_5678, 32'h1234_5678, 32'h1234_5678,
                                         32'h1234_5678, 32'h1234_5678, 32'h1234_5678,
                                         32'h1234_5678, 32'h1234_5678, 32'h7878_7878,
                                         32'h7878_7878, 32'h1234_5678, 32'h1234_5678};
  localparam logic [3:0]  V_STRB [NV] = '{4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0,
                                         4'h0, 4'h0, 4'h4, 4'h1, 4'hF, 4'hF};
  localparam logic [31:0] V_LD   [NV] = '{32'h0000_00D4, 32'h0000_00C3, 32'h0000_00B2,
                                         32'h0000_00A1, 32'hA1B2_C3D4, 32'hD4A1_B2C3,
                                         32'hC3D4_A1B2, 32'hB2C3_D4A1, 32'h0, 32'h0,
                                         32'h0, 32'h0};

  function automatic logic [31:0] ref_load(input logic [1:0] k, input logic [1:0] o,
                                           input logic [31:0] rd);
    logic [31:0] r;
    r = (rd >> (8 * o)) | (rd << (32 - 8 * o));
    if (o == 2'd0) r = rd;
    return k[0] ? r : {24'h0, r[7:0]};
  endfunction

  function automatic logic [31:0] ref_wdata(input logic [1:0] k, input logic [31:0] sd);
    return k[0] ? sd : {4{sd[7:0]}};
  endfunction

  function automatic logic [3:0] ref_strb(input logic [1:0] k, input logic [1:0] o);
    if (!k[1]) return 4'h0;
    if (k[0]) return 4'hF;
    return 4'(1) << o;
  endfunction

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One access: drive at a falling edge, check stores combinationally,
  // check the load register at the next falling edge (one rising edge later).
  task automatic apply(input logic [1:0] k, input logic [1:0] o, input logic [31:0] sd,
                       input logic [31:0] rd, input logic [31:0] exp_wd,
                       input logic [3:0] exp_sb, input logic [31:0] exp_ld);
    logic [31:0] prev_ld;
    @(negedge clk);
    prev_ld  = ld_data;
    acc_kind = k; addr_lo = o; st_data = sd; rd_data = rd; rd_valid = 1'b1;
    #1;
    if (k[1]) begin
      check32(k[0] ? "R6 word store data" : "R5 byte store data", bus_wdata, exp_wd);
    end
    check32("R7 strobes", {28'h0, bus_wstrb}, {28'h0, exp_sb});
    @(negedge clk);
    if (k[1]) begin
      check32("R8 store kind gives no valid", {31'h0, ld_valid}, 32'h0);
      check32("R8 store kind holds load data", ld_data, prev_ld);
    end else begin
      check32("R8 load valid", {31'h0, ld_valid}, 32'h1);
      check32(k[0] ? (o == 2'd2 ? "R4 halfword rotate" : "R3 word rotate")
                   : "R1 R2 byte select and zero fill", ld_data, exp_ld);
    end
    rd_valid = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] held;
    rst = 1'b1; acc_kind = 2'd0; addr_lo = 2'd0; st_data = '0;
    rd_valid = 1'b1; rd_data = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    // R9: reset wins over a capture request.
    check32("R9 reset valid", {31'h0, ld_valid}, 32'h0);
    check32("R9 reset data", ld_data, 32'h0);
    rst = 1'b0; rd_valid = 1'b0;
    @(negedge clk);

    // Table walk.
    for (int i = 0; i < NV; i++) begin
      apply(V_KIND[i], V_OFF[i], V_ST, V_RD, V_WD[i], V_STRB[i], V_LD[i]);
    end

    // Every kind and offset with random data against the reference model.
    for (int rep = 0; rep < 3; rep++) begin
      for (int k = 0; k < 4; k++) begin
        for (int o = 0; o < 4; o++) begin
          logic [31:0] sd;
          logic [31:0] rd;
          sd = $urandom; rd = $urandom;
          apply(2'(k), 2'(o), sd, rd, ref_wdata(2'(k), sd), ref_strb(2'(k), 2'(o)),
                ref_load(2'(k), 2'(o), rd));
        end
      end
    end

    // R8: no capture without rd_valid; data holds, valid drops.
    apply(2'd1, 2'd0, 32'h0, 32'hCAFE_F00D, 32'h0, 4'h0, 32'hCAFE_F00D);
    held = ld_data;
    @(negedge clk);
    acc_kind = 2'd0; addr_lo = 2'd3; rd_data = 32'h1111_1111; rd_valid = 1'b0;
    @(negedge clk);
    check32("R8 idle drops valid", {31'h0, ld_valid}, 32'h0);
    check32("R8 idle holds data", ld_data, held);

    // R9: reset after a capture clears the register.
    apply(2'd0, 2'd3, 32'h0, 32'h9900_0000, 32'h0, 4'h0, 32'h0000_0099);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check32("R9 mid-run reset valid", {31'h0, ld_valid}, 32'h0);
    check32("R9 mid-run reset data", ld_data, 32'h0);
    rst = 1'b0;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule